// File: doc/BRIEF.md
# I/O Virtual Address Page-Table Translator

This block turns a 32-bit I/O virtual address from a bus master into a 36-bit physical address by looking it up in a one-level page table in memory. Each accepted request takes the part of the address that falls inside the configured translation window. The block adds the page index of that part, scaled to a 4-byte entry, to the table base. It then issues one 32-bit read of that entry on a memory read port.

When the entry comes back, the block checks the entry's valid and writable flags. It then answers the master with either a translated address and its access permission, or a fault. On a fault it also sends a one-cycle update to the error register file. The update carries an encoded status word and the page-aligned address that caused the fault. The same pulse is the interrupt request.

The block accepts a new request only after the master has taken the previous response, so only one translation is in flight at a time. It keeps no cache of entries. The table base and the window size come in as static configuration inputs.

Top module: `dvma_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req_valid`, `rsp_valid` and `flt_we` are 0.
- R2: The window spans 2^(24+`cfg_range`) bytes at the top of the 32-bit space, so `cfg_range` 0 gives 16 MB and 7 gives 2 GB. The offset is the request address with every bit at or above that size cleared. `mem_req_addr` equals (`cfg_base` << 4) + ((offset >> 10) with its two low bits cleared), truncated to 32 bits. It is held stable while `mem_req_valid` is high and `mem_req_ready` is low.
- R3: The entry is a big-endian word. `mem_rsp_data[7:0]` is the byte at the lowest address and becomes entry bits 31:24, and `mem_rsp_data[31:24]` becomes entry bits 7:0. In the entry, bits 31:8 are the physical page number PA[35:12], bit 7 is cacheable, bit 2 is writable, bit 1 is valid and bit 0 is write-as-zero.
- R4: On success, `rsp_paddr` equals {entry[31:8], request address[11:0]}.
- R5: An entry whose valid bit is 0 yields `rsp_fault`=1.
- R6: A write request to an entry whose writable bit is 0 yields `rsp_fault`=1. A read request to that same entry succeeds.
- R7: On success, `rsp_rw` is 1 when the entry's writable bit is 1 and 0 when it is 0. On a fault, `rsp_rw` and `rsp_paddr` are 0.
- R8: On a fault, `flt_we` pulses for exactly the first cycle in which `rsp_valid` is high. In that cycle `flt_status` is 0xE0A20000 for a write and 0xE0A60000 for a read (bit 18 marks a read). `flt_addr` is the request address with bits 11:0 cleared.
- R9: A memory read error (`mem_rsp_err`=1) is a fault, reported exactly as in R8, whatever the entry bits hold.
- R10: `req_ready` is 0 from the cycle after a request is accepted until the response has been taken. `rsp_valid` and the `rsp_*` values hold until `rsp_ready` is 1.
- R11: A successful translation never raises `flt_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Page-table base; bits 27:0 are used, shifted left by 4 |
| cfg_range | input | 3 | Window size code (16 MB << code) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | I/O virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the entry read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 32 | Entry read data, lowest-address byte in bits 7:0 |
| mem_rsp_err | input | 1 | Entry read failed |
| rsp_valid | output | 1 | Translation response valid |
| rsp_ready | input | 1 | Master takes the response |
| rsp_fault | output | 1 | Translation faulted |
| rsp_paddr | output | 36 | Translated physical address |
| rsp_rw | output | 1 | 1 = read-write page, 0 = read-only |
| flt_we | output | 1 | One-cycle error-register update and interrupt request |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | 32 | Page-aligned faulting address |

## Verification
The hardest case to reach is a memory read error that arrives together with an entry that looks valid and writable. Only an error flag set on a well-formed entry shows that the error wins over the flags. The bench repeats its sweep with the error flag forced on and a fully permissive entry, for every window size and both access directions. Back-pressure on both the memory request and the response is applied on every other transaction, so the hold rules of R2 and R10 are checked with the block stalled.

// File: rtl/dvma_pkg.sv
package dvma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_e;

  // page-table entry layout, most significant field first
  typedef struct packed {
    logic [23:0] ppn;
    logic        cacheable;
    logic [3:0]  unused;
    logic        writable;
    logic        valid;
    logic        wr_zero;
  } pte_t;

  localparam logic [31:0] FLT_STATUS_BASE = 32'hE0A2_0000;
  localparam logic [31:0] FLT_STATUS_READ = 32'h0004_0000;

endpackage

// File: rtl/dvma_ptaddr.sv
module dvma_ptaddr #(
  parameter int VA_W         = 32,
  parameter int RNG_W        = 3,
  parameter int WIN_MIN_LOG2 = 24,
  parameter int PAGE_SHIFT   = 12
) (
  input  logic [VA_W-1:0]  va,
  input  logic [RNG_W-1:0] rng,
  input  logic [VA_W-1:0]  base,
  output logic [VA_W-1:0]  ent_addr
);
  localparam logic [VA_W-1:0] ONE = {{(VA_W-1){1'b0}}, 1'b1};
  localparam int ENT_LOG2 = 2;

  logic [VA_W-1:0] win_mask;
  logic [VA_W-1:0] offset;
  logic [VA_W-1:0] tbl_base;
  logic [VA_W-1:0] ent_off;

  always_comb begin
    win_mask = (ONE << (WIN_MIN_LOG2 + int'(rng))) - ONE;
    offset   = va & win_mask;
    tbl_base = {base[VA_W-5:0], 4'b0000};
    ent_off  = (offset >> PAGE_SHIFT) << ENT_LOG2;
    ent_addr = tbl_base + ent_off;
  end
endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check
  import dvma_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 36,
  parameter int PAGE_SHIFT = 12,
  parameter bit ENTRY_BE   = 1'b1
) (
  input  logic [31:0]     raw_word,
  input  logic            bus_err,
  input  logic            is_write,
  input  logic [VA_W-1:0] va,
  output logic            fault,
  output logic [PA_W-1:0] paddr,
  output logic            rw,
  output logic [31:0]     status,
  output logic [VA_W-1:0] fault_addr
);
  logic [31:0] ent_word;
  pte_t        ent;

  generate
    if (ENTRY_BE) begin : g_swap
      assign ent_word = {raw_word[7:0], raw_word[15:8], raw_word[23:16], raw_word[31:24]};
    end else begin : g_direct
      assign ent_word = raw_word;
    end
  endgenerate

  assign ent = pte_t'(ent_word);

  always_comb begin
    fault      = bus_err | ~ent.valid | (is_write & ~ent.writable);
    paddr      = fault ? '0 : {ent.ppn, va[PAGE_SHIFT-1:0]};
    rw         = ~fault & ent.writable;
    status     = FLT_STATUS_BASE | (is_write ? 32'h0 : FLT_STATUS_READ);
    fault_addr = {va[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/dvma_seq.sv
module dvma_seq
  import dvma_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 36
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_addr,
  input  logic            req_write,
  input  logic [VA_W-1:0] ent_addr_in,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [VA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  output logic [VA_W-1:0] va_q,
  output logic            wr_q,
  input  logic            chk_fault,
  input  logic [PA_W-1:0] chk_paddr,
  input  logic            chk_rw,
  input  logic [31:0]     chk_status,
  input  logic [VA_W-1:0] chk_faddr,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_fault,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_rw,
  output logic            flt_we,
  output logic [31:0]     flt_status,
  output logic [VA_W-1:0] flt_addr
);
  xl_state_e state_q, state_d;
  logic      req_take, rsp_take, rsp_done;
  logic      flt_we_d;
  logic [VA_W-1:0] ent_q;

  assign req_take = (state_q == ST_IDLE)  & req_valid;
  assign rsp_take = (state_q == ST_WAIT)  & mem_rsp_valid;
  assign rsp_done = (state_q == ST_RESP)  & rsp_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid)     state_d = ST_FETCH;
      ST_FETCH: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = ST_RESP;
      ST_RESP:  if (rsp_ready)     state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
    flt_we_d = rsp_take & chk_fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      flt_we  <= 1'b0;
    end else begin
      state_q <= state_d;
      flt_we  <= flt_we_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk) begin
    if (req_take) begin
      va_q  <= req_addr;
      wr_q  <= req_write;
      ent_q <= ent_addr_in;
    end
  end

  // response capture, enabled when the entry arrives
  always_ff @(posedge clk) begin
    if (rsp_take) begin
      rsp_fault  <= chk_fault;
      rsp_paddr  <= chk_paddr;
      rsp_rw     <= chk_rw;
      flt_status <= chk_status;
      flt_addr   <= chk_faddr;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_FETCH);
  assign mem_req_addr  = ent_q;
  assign rsp_valid     = (state_q == ST_RESP);

  logic unused_done;
  assign unused_done = rsp_done;
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
#(
  parameter int VA_W         = 32,
  parameter int PA_W         = 36,
  parameter int RNG_W        = 3,
  parameter int WIN_MIN_LOG2 = 24,
  parameter int PAGE_SHIFT   = 12,
  parameter bit ENTRY_BE     = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  cfg_base,
  input  logic [RNG_W-1:0] cfg_range,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_addr,
  input  logic             req_write,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [VA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  input  logic             mem_rsp_err,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_rw,
  output logic             flt_we,
  output logic [31:0]      flt_status,
  output logic [VA_W-1:0]  flt_addr
);
  logic [VA_W-1:0] ent_addr;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic            chk_fault, chk_rw;
  logic [PA_W-1:0] chk_paddr;
  logic [31:0]     chk_status;
  logic [VA_W-1:0] chk_faddr;

  dvma_ptaddr #(
    .VA_W(VA_W), .RNG_W(RNG_W), .WIN_MIN_LOG2(WIN_MIN_LOG2), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_ptaddr (
    .va(req_addr), .rng(cfg_range), .base(cfg_base), .ent_addr(ent_addr)
  );

  dvma_pte_check #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_BE(ENTRY_BE)
  ) u_check (
    .raw_word(mem_rsp_data), .bus_err(mem_rsp_err), .is_write(wr_q), .va(va_q),
    .fault(chk_fault), .paddr(chk_paddr), .rw(chk_rw), .status(chk_status),
    .fault_addr(chk_faddr)
  );

  dvma_seq #(.VA_W(VA_W), .PA_W(PA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .ent_addr_in(ent_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .va_q(va_q), .wr_q(wr_q),
    .chk_fault(chk_fault), .chk_paddr(chk_paddr), .chk_rw(chk_rw),
    .chk_status(chk_status), .chk_faddr(chk_faddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_rw(rsp_rw),
    .flt_we(flt_we), .flt_status(flt_status), .flt_addr(flt_addr)
  );
endmodule

// File: rtl/dvma_xlate_chk.sv
module dvma_xlate_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [VA_W-1:0] mem_req_addr,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_rw,
  input logic            flt_we,
  input logic [31:0]     flt_status,
  input logic [VA_W-1:0] flt_addr
);
  a_r2_entry_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_rw));

  a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    flt_we |=> !flt_we);

  a_r8_pulse_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    flt_we |-> rsp_valid && rsp_fault && $rose(rsp_valid));

  a_r8_status_form: assert property (@(posedge clk) disable iff (!rst_n)
    flt_we |-> (flt_addr[11:0] == 12'h000) && ((flt_status & 32'hFFFB_FFFF) == 32'hE0A2_0000));

  a_r11_no_pulse_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !rsp_fault |-> !flt_we);

  a_r7_fault_clears_result: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !rsp_rw && (rsp_paddr == '0));

  logic unused_rv;
  assign unused_rv = req_valid;
endmodule

bind dvma_xlate dvma_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .rsp_rw(rsp_rw), .flt_we(flt_we),
  .flt_status(flt_status), .flt_addr(flt_addr)
);

// File: tb/dvma_xlate_bench.sv
module dvma_xlate_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_base;
  logic [2:0]  cfg_range;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid, rsp_ready, rsp_fault, rsp_rw, flt_we;
  logic [35:0] rsp_paddr;
  logic [31:0] flt_status, flt_addr;

  int n_chk = 0;
  int n_bad = 0;

  dvma_xlate u_dvma_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_range(cfg_range),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_rw(rsp_rw),
    .flt_we(flt_we), .flt_status(flt_status), .flt_addr(flt_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] addr, input logic wr, input logic [31:0] pte,
                       input logic err, input logic stall);
    logic [31:0] win, eaddr, status;
    logic        flt;
    logic [35:0] pa;
    win   = (32'h0100_0000 << cfg_range) - 32'h1;
    eaddr = (cfg_base << 4) + (((addr & win) >> 10) & ~32'h3);
    flt   = err | !pte[1] | (wr & !pte[2]);
    pa    = flt ? 36'h0 : {pte[31:8], addr[11:0]};
    status = wr ? 32'hE0A2_0000 : 32'hE0A6_0000;

    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 32'h0;
    check("R2 mem_req_valid", 64'(mem_req_valid), 64'h1);
    check("R2 entry address", 64'(mem_req_addr), 64'(eaddr));
    check("R10 req_ready low", 64'(req_ready), 64'h0);
    if (stall) begin
      @(negedge clk);
      check("R2 entry address held", 64'(mem_req_addr), 64'(eaddr));
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b1;
    mem_rsp_err   = err;
    mem_rsp_data  = {pte[7:0], pte[15:8], pte[23:16], pte[31:24]}; // R3 byte order
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
    check("R10 rsp_valid", 64'(rsp_valid), 64'h1);
    check(err ? "R9 fault on bus error" : (!pte[1] ? "R5 invalid fault" : "R6 write permission"),
          64'(rsp_fault), 64'(flt));
    check("R4 R3 physical address", 64'(rsp_paddr), 64'(pa));
    check("R7 permission", 64'(rsp_rw), 64'(!flt & pte[2]));
    check(flt ? "R8 fault pulse" : "R11 no pulse", 64'(flt_we), 64'(flt));
    if (flt) begin
      check("R8 status", 64'(flt_status), 64'(status));
      check("R8 fault address", 64'(flt_addr), 64'({addr[31:12], 12'h000}));
    end
    if (stall) begin
      @(negedge clk);
      check("R10 rsp held", 64'({rsp_valid, rsp_fault, rsp_paddr}), 64'({1'b1, flt, pa}));
      check("R8 pulse ends", 64'(flt_we), 64'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R10 back to idle", 64'({req_ready, rsp_valid}), 64'h2);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_base = 32'h0; cfg_range = 3'd0;
    req_valid = 1'b0; req_addr = 32'h0; req_write = 1'b0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = 32'h0;
    rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", 64'({req_ready, mem_req_valid, rsp_valid, flt_we}), 64'h8);

    for (int code = 0; code < 8; code++) begin
      cfg_range = 3'(code);
      cfg_base  = 32'h0012_3400 + 32'(code) * 32'h0001_0400;
      for (int k = 0; k < 8; k++) begin
        logic [31:0] a, p;
        a = 32'hF000_0ABC ^ (32'(code * 8 + k) * 32'h0765_4321);
        p = (32'h1234_5600 + 32'(k) * 32'h00AB_CD00) & 32'hFFFF_FF00;
        p = p | {24'h0, (k[0] ? 1'b1 : 1'b0), 4'b0000, k[2], k[1], 1'b0};
        xlate(a, k[0] ^ k[2] ^ code[0], p, 1'b0, k[0]);
      end
      xlate(32'hFFFF_F123 - 32'(code) * 32'h0123_4000, 1'b0, 32'hABCD_EF86, 1'b1, 1'b1);
      xlate(32'h8765_4321 + 32'(code) * 32'h0100_1000, 1'b1, 32'h1111_1186, 1'b1, 1'b0);
    end
    // read of a read-only page succeeds (R6)
    xlate(32'hFF12_3456, 1'b0, 32'h0FED_CB02, 1'b0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule